// File: doc/BRIEF.md
# Byte EEPROM access controller

This block lets a CPU read and write single bytes of a byte-addressed nonvolatile array that sits in its own data space, separate from the CPU's working memory. Software sees four registers: two hold the byte address (low byte and high bits), one holds the data byte, and one is a command/status register. Setting a command bit starts an operation. While the operation runs, the block holds the CPU in a stall.

A read stalls the CPU for four cycles and leaves the addressed byte in the data register. A write stalls the CPU for two cycles. The array update then runs in the background for a programmable number of cycles, and a busy flag tells software when the next byte may be written. A write command is honoured only inside a short window opened by a separate arming command. The window closes by itself, so a stray write command cannot reach the array.

Top module: `nvbyte_ctrl`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a write, `cpu_stall`, `mem_we` and `wr_done` are 0, the command/status register (register 3) reads 0, and no array write takes place.
- R2: A bus write to register 0 sets address bits 7:0. A bus write to register 1 sets address bits 9:8 from data bits 1:0, and register 1 reads back with bits 7:2 at 0. When idle, `mem_addr` shows the assembled 10-bit address.
- R3: A bus write of register 3 with bit 0 (read command) set, while idle, raises `cpu_stall` for exactly 4 cycles, starting in the cycle after the bus write.
- R4: When a read ends, register 2 holds the array byte at the programmed address. It is loaded on the last stall cycle.
- R5: A bus write of register 3 with bit 2 (arm) set makes bit 2 read 1 for the 4 cycles that follow. The bit then clears by itself.
- R6: A write command (register 3 bit 1) outside the arm window is ignored: no stall, no busy and no `mem_we`. An arm and a write command in the same bus write count as outside the window.
- R7: A write command inside the arm window raises `cpu_stall` for exactly 2 cycles.
- R8: An accepted write sets busy (register 3 bit 3) for WR_CYCLES cycles. `mem_we` pulses once, in the last busy cycle, carrying the address and data captured when the command was accepted.
- R9: Read and write commands issued while busy are ignored, and so are later changes to the address and data registers.
- R10: `wr_done` pulses for one cycle, in the first cycle after busy falls.
- R11: Command bits 0 and 1 always read back as 0.
- R12: An accepted write closes the arm window at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_reg | input | 2 | Register index: 0 addr low, 1 addr high, 2 data, 3 command/status |
| bus_wdata | input | 8 | Write data from the CPU |
| bus_rdata | output | 8 | Read data of the register selected by bus_reg |
| cpu_stall | output | 1 | Holds the CPU while an operation starts |
| wr_done | output | 1 | One-cycle pulse when a background write has finished |
| mem_addr | output | 10 | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write enable, one cycle per write |
| mem_rdata | input | 8 | Array read data for mem_addr, valid in the same cycle |

## Verification
The assertions assume that the CPU issues no register access while `cpu_stall` is high, and that the array returns the byte for `mem_addr` in the same cycle. The bench drives the bus only between stall windows and models the array as a combinational-read memory. Commands issued during busy are sent on purpose, and only after the stall has ended, so that the ignore rule is tested on its own and not mixed up with stall handling.

// File: rtl/nvb_pkg.sv
`timescale 1ns/1ps
package nvb_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] REG_ALO = 2'd0;
  localparam logic [1:0] REG_AHI = 2'd1;
  localparam logic [1:0] REG_DAT = 2'd2;
  localparam logic [1:0] REG_CTL = 2'd3;

  localparam int B_RD   = 0;
  localparam int B_WR   = 1;
  localparam int B_ARM  = 2;
  localparam int B_BUSY = 3;

  typedef enum logic [0:0] {OP_RD = 1'b0, OP_WR = 1'b1} op_e;

  // status view of the command register; command bits never read back
  function automatic logic [BYTE_W-1:0] ctrl_word(input logic busy, input logic armed);
    logic [BYTE_W-1:0] w;
    w = '0;
    w[B_BUSY] = busy;
    w[B_ARM]  = armed;
    return w;
  endfunction

  function automatic logic is_ctl_write(input logic sel, input logic wr, input logic [1:0] idx);
    return sel && wr && (idx == REG_CTL);
  endfunction
endpackage

// File: rtl/nvb_regs.sv
`timescale 1ns/1ps
module nvb_regs
  import nvb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              busy,
  input  logic              armed,
  output logic [AW-1:0]     addr,
  output logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] rdata
);
  localparam int HI_W = AW - BYTE_W;

  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_en && sel == REG_ALO) addr_q[BYTE_W-1:0] <= wdata;
      if (wr_en && sel == REG_AHI) addr_q[AW-1:BYTE_W] <= wdata[HI_W-1:0];
      if (load_en)                        data_q <= load_val;
      else if (wr_en && sel == REG_DAT)   data_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      REG_ALO: rdata = addr_q[BYTE_W-1:0];
      REG_AHI: rdata = {{(BYTE_W-HI_W){1'b0}}, addr_q[AW-1:BYTE_W]};
      REG_DAT: rdata = data_q;
      default: rdata = ctrl_word(busy, armed);
    endcase
  end

  assign addr = addr_q;
  assign data = data_q;
endmodule

// File: rtl/nvb_guard.sv
`timescale 1ns/1ps
module nvb_guard #(
  parameter int ARM_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_req,
  input  logic consume,
  output logic arm_open
);
  localparam int CW = $clog2(ARM_WIN + 1);

  logic [CW-1:0] win_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             win_cnt <= '0;
    else if (consume)       win_cnt <= '0;
    else if (arm_req)       win_cnt <= CW'(ARM_WIN);
    else if (win_cnt != '0) win_cnt <= win_cnt - 1'b1;
  end

  assign arm_open = (win_cnt != '0);
endmodule

// File: rtl/nvb_seq.sv
`timescale 1ns/1ps
module nvb_seq
  import nvb_pkg::*;
#(
  parameter int AW        = 10,
  parameter int RD_STALL  = 4,
  parameter int WR_STALL  = 2,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_accept,
  input  logic              wr_accept,
  input  logic [AW-1:0]     addr_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic              stall,
  output logic              busy,
  output logic              rd_load,
  output logic              commit,
  output logic              done,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int SW = $clog2(STALL_MAX + 1);
  localparam int BW = $clog2(WR_CYCLES + 1);

  logic [SW-1:0]     stall_cnt;
  logic [BW-1:0]     busy_cnt;
  op_e               op_q;
  logic              done_q;
  logic [AW-1:0]     wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_cnt <= '0;
      busy_cnt  <= '0;
      op_q      <= OP_RD;
      done_q    <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      if (rd_accept) begin
        stall_cnt <= SW'(RD_STALL);
        op_q      <= OP_RD;
      end else if (wr_accept) begin
        stall_cnt <= SW'(WR_STALL);
        op_q      <= OP_WR;
      end else if (stall_cnt != '0) begin
        stall_cnt <= stall_cnt - 1'b1;
      end

      if (wr_accept) begin
        busy_cnt  <= BW'(WR_CYCLES);
        wr_addr_q <= addr_in;
        wr_data_q <= data_in;
      end else if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
      end

      done_q <= commit;
    end
  end

  assign stall   = (stall_cnt != '0);
  assign busy    = (busy_cnt != '0);
  assign rd_load = (stall_cnt == SW'(1)) && (op_q == OP_RD);
  assign commit  = (busy_cnt == BW'(1));
  assign done    = done_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
endmodule

// File: rtl/nvbyte_ctrl.sv
`timescale 1ns/1ps
module nvbyte_ctrl
  import nvb_pkg::*;
#(
  parameter int AW        = 10,
  parameter int RD_STALL  = 4,
  parameter int WR_STALL  = 2,
  parameter int WR_CYCLES = 40,
  parameter int ARM_WIN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_reg,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              cpu_stall,
  output logic              wr_done,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata
);
  // named internal events, also observed by the bound checker
  logic              ctl_wr;
  logic              idle;
  logic              arm_open;
  logic              rd_accept;
  logic              wr_accept;
  logic              rd_load;
  logic              busy;
  logic [AW-1:0]     reg_addr;
  logic [BYTE_W-1:0] reg_data;
  logic [AW-1:0]     wr_addr;

  assign ctl_wr    = is_ctl_write(bus_sel, bus_wr, bus_reg);
  assign idle      = !cpu_stall && !busy;
  assign wr_accept = ctl_wr && bus_wdata[B_WR] && idle && arm_open;
  assign rd_accept = ctl_wr && bus_wdata[B_RD] && idle && !wr_accept;

  nvb_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_sel && bus_wr),
    .sel      (bus_reg),
    .wdata    (bus_wdata),
    .load_en  (rd_load),
    .load_val (mem_rdata),
    .busy     (busy),
    .armed    (arm_open),
    .addr     (reg_addr),
    .data     (reg_data),
    .rdata    (bus_rdata)
  );

  nvb_guard #(.ARM_WIN(ARM_WIN)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_req  (ctl_wr && bus_wdata[B_ARM]),
    .consume  (wr_accept),
    .arm_open (arm_open)
  );

  nvb_seq #(
    .AW(AW), .RD_STALL(RD_STALL), .WR_STALL(WR_STALL), .WR_CYCLES(WR_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_accept (rd_accept),
    .wr_accept (wr_accept),
    .addr_in   (reg_addr),
    .data_in   (reg_data),
    .stall     (cpu_stall),
    .busy      (busy),
    .rd_load   (rd_load),
    .commit    (mem_we),
    .done      (wr_done),
    .wr_addr   (wr_addr),
    .wr_data   (mem_wdata)
  );

  assign mem_addr = busy ? wr_addr : reg_addr;
endmodule

// File: rtl/nvbyte_ctrl_chk.sv
`timescale 1ns/1ps
module nvbyte_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_stall,
  input logic wr_done,
  input logic mem_we,
  input logic busy,
  input logic arm_open,
  input logic rd_accept,
  input logic wr_accept,
  input logic rd_load
);
  p_rd_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> cpu_stall && !busy);

  p_rd_load_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> !cpu_stall);

  p_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> arm_open);

  p_wr_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> cpu_stall && busy);

  p_commit_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_commit_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we && !busy);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || cpu_stall) |-> !(rd_accept || wr_accept));

  p_done_after_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(mem_we));

  p_window_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !arm_open);
endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_stall (cpu_stall),
  .wr_done   (wr_done),
  .mem_we    (mem_we),
  .busy      (busy),
  .arm_open  (arm_open),
  .rd_accept (rd_accept),
  .wr_accept (wr_accept),
  .rd_load   (rd_load)
);

// File: tb/test_nvbyte_ctrl.sv
`timescale 1ns/1ps
module test_nvbyte_ctrl;
  localparam int AW = 10;
  localparam int WR_CYCLES = 40;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] R_ALO = 2'd0, R_AHI = 2'd1, R_DAT = 2'd2, R_CTL = 2'd3;
  localparam logic [7:0] C_RD = 8'h01, C_WR = 8'h02, C_ARM = 8'h04;

  // vector: {addr[19:10], data[9:2], gap[1:0]} gap = idle cycles between arm and write
  localparam int NV = 5;
  localparam logic [19:0] VEC [NV] = '{
    {10'h000, 8'h3C, 2'd0},
    {10'h3FF, 8'hC3, 2'd3},
    {10'h155, 8'h00, 2'd1},
    {10'h2AA, 8'hFF, 2'd2},
    {10'h0F0, 8'h81, 2'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_reg = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cpu_stall, wr_done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic       mem_init = 1'b1;
  logic [7:0] mem_m [DEPTH];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nvbyte_ctrl #(.WR_CYCLES(WR_CYCLES)) i_nvbyte_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_stall(cpu_stall), .wr_done(wr_done), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] seed_byte(input int a);
    return 8'(a) ^ 8'h5A ^ {6'h0, 2'(a >> 8)};
  endfunction

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < DEPTH; i++) mem_m[i] <= seed_byte(i);
    end else if (mem_we) begin
      mem_m[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = mem_m[mem_addr];

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] r, input logic [7:0] v);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_reg = r; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic read_reg(input logic [1:0] r, output logic [7:0] v);
    bus_reg = r;
    #1;
    v = bus_rdata;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (cpu_stall && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  // arm, wait gap cycles, issue write; measure stall, busy, commit and done
  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input int gap);
    int n, st, we_n, we_at;
    logic [7:0] v;
    bus_write(R_ALO, a[7:0]);
    bus_write(R_AHI, {6'h0, a[9:8]});
    bus_write(R_DAT, d);
    bus_write(R_CTL, C_ARM);
    repeat (gap) @(negedge clk);
    bus_write(R_CTL, C_WR);
    read_reg(R_CTL, v);
    chk("R12 window closed after accepted write", int'(v[2]), 0);
    n = 0; st = 0; we_n = 0; we_at = -1;
    while (v[3] && n < 1000) begin
      if (cpu_stall) st++;
      if (mem_we) begin
        we_n++; we_at = n;
        chk("R8 commit address", int'(mem_addr), int'(a));
        chk("R8 commit data", int'(mem_wdata), int'(d));
      end
      n++;
      @(negedge clk);
      read_reg(R_CTL, v);
    end
    chk("R8 busy length", n, WR_CYCLES);
    chk("R8 single commit", we_n, 1);
    chk("R8 commit in last busy cycle", we_at, WR_CYCLES - 1);
    chk("R7 write stall length", st, 2);
    chk("R10 done pulse after busy", int'(wr_done), 1);
    @(negedge clk);
    chk("R10 done pulse one cycle", int'(wr_done), 0);
    chk("R8 array updated", int'(mem_m[a]), int'(d));
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] exp);
    int n;
    logic [7:0] v;
    bus_write(R_ALO, a[7:0]);
    bus_write(R_AHI, {6'h0, a[9:8]});
    bus_write(R_CTL, C_RD);
    count_stall(n);
    chk("R3 read stall length", n, 4);
    read_reg(R_DAT, v);
    chk("R4 read data", int'(v), int'(exp));
  endtask

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    mem_init = 1'b0;
    // R1 reset state
    chk("R1 stall at reset", int'(cpu_stall), 0);
    chk("R1 mem_we at reset", int'(mem_we), 0);
    chk("R1 done at reset", int'(wr_done), 0);
    read_reg(R_CTL, v);
    chk("R1 status at reset", int'(v), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 address assembly
    bus_write(R_ALO, 8'h34);
    bus_write(R_AHI, 8'hFF);
    read_reg(R_AHI, v);
    chk("R2 high address readback", int'(v), 8'h03);
    read_reg(R_ALO, v);
    chk("R2 low address readback", int'(v), 8'h34);
    chk("R2 mem_addr", int'(mem_addr), 10'h334);

    // R3/R4/R11 read
    bus_write(R_CTL, C_RD);
    read_reg(R_CTL, v);
    chk("R11 command bits read 0", int'(v[1:0]), 0);
    count_stall(n);
    chk("R3 read stall length", n, 4);
    read_reg(R_DAT, v);
    chk("R4 read data", int'(v), int'(seed_byte(10'h334)));

    // R6 unarmed write, and arm+write in one access
    bus_write(R_DAT, 8'hEE);
    bus_write(R_CTL, C_WR);
    chk("R6 unarmed write no stall", int'(cpu_stall), 0);
    read_reg(R_CTL, v);
    chk("R6 unarmed write no busy", int'(v[3]), 0);
    bus_write(R_CTL, C_WR | C_ARM);
    chk("R6 same-access arm no stall", int'(cpu_stall), 0);
    read_reg(R_CTL, v);
    chk("R6 same-access arm no busy", int'(v[3]), 0);
    chk("R5 arm opened by combined access", int'(v[2]), 1);
    repeat (6) @(negedge clk);
    chk("R6 array untouched", int'(mem_m[10'h334]), int'(seed_byte(10'h334)));

    // R5 arm window length, then expired write rejected
    bus_write(R_CTL, C_ARM);
    for (int i = 0; i < 4; i++) begin
      read_reg(R_CTL, v);
      chk("R5 arm bit inside window", int'(v[2]), 1);
      @(negedge clk);
    end
    read_reg(R_CTL, v);
    chk("R5 arm bit cleared after window", int'(v[2]), 0);
    bus_write(R_CTL, C_WR);
    chk("R6 expired window no stall", int'(cpu_stall), 0);
    read_reg(R_CTL, v);
    chk("R6 expired window no busy", int'(v[3]), 0);

    // table of writes, each read back
    for (int k = 0; k < NV; k++) begin
      do_write(VEC[k][19:10], VEC[k][9:2], int'(VEC[k][1:0]));
      do_read(VEC[k][19:10], VEC[k][9:2]);
    end

    // R9 commands and register changes while busy are ignored
    bus_write(R_ALO, 8'h11);
    bus_write(R_AHI, 8'h01);
    bus_write(R_DAT, 8'h77);
    bus_write(R_CTL, C_ARM);
    bus_write(R_CTL, C_WR);
    count_stall(n);
    bus_write(R_CTL, C_RD);
    chk("R9 read during busy no stall", int'(cpu_stall), 0);
    bus_write(R_DAT, 8'h99);
    bus_write(R_ALO, 8'h22);
    bus_write(R_CTL, C_ARM);
    bus_write(R_CTL, C_WR);
    chk("R9 write during busy no stall", int'(cpu_stall), 0);
    n = 0;
    read_reg(R_CTL, v);
    while (v[3] && n < 1000) begin
      n++;
      @(negedge clk);
      read_reg(R_CTL, v);
    end
    @(negedge clk);
    chk("R9 captured write kept", int'(mem_m[10'h111]), 8'h77);
    chk("R9 later address untouched", int'(mem_m[10'h122]), int'(seed_byte(10'h122)));
    chk("R9 no second commit", int'(mem_we), 0);

    // R1 reset during a background write
    bus_write(R_ALO, 8'h40);
    bus_write(R_AHI, 8'h00);
    bus_write(R_DAT, 8'hA1);
    bus_write(R_CTL, C_ARM);
    bus_write(R_CTL, C_WR);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_reg(R_CTL, v);
    chk("R1 status after mid-write reset", int'(v), 0);
    chk("R1 stall after mid-write reset", int'(cpu_stall), 0);
    repeat (WR_CYCLES + 4) @(negedge clk);
    chk("R1 aborted write not committed", int'(mem_m[10'h040]), int'(seed_byte(10'h040)));
    chk("R1 no done after abort", int'(wr_done), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule